// File: doc/BRIEF.md
# Thermal clock modulation controller

This block is the last stage of thermal throttling for a processor core. Once the thermal control circuit is active and the frequency and voltage targets are already at their lowest setting, it gates the core clock with a fixed pattern. The clock runs for a quarter of each period and is held off for the remaining three quarters. The period is measured in ticks of a fixed-rate timebase (one tick per microsecond, 32 ticks per period). Because of this, the on/off timing stays the same whatever frequency the core clock is running at.

The control circuit turns on as soon as the die reports a temperature above its maximum. It turns off only after the temperature has stayed below the maximum for a whole hysteresis interval, counted in timebase ticks. When the control circuit turns off, or when the frequency and voltage targets leave their minimum, modulation stops. The clock enable then goes high in that same cycle, and the period counter returns to zero. The only thing this block gates is the core clock enable. Snoop and interrupt servicing are clocked elsewhere and keep running at all times.

Top module: `thermal_clkmod`

## Requirements
- R1: While reset is held, and directly after it, `core_clk_en` is 1 and both `tcc_on` and `mod_on` are 0.
- R2: `tcc_on` rises on the first clock edge at which `over_tmax` is sampled 1.
- R3: `mod_on` is 1 in exactly those cycles that follow an edge at which the control circuit's next state was active and `fv_floor` was 1. It is never 1 while `tcc_on` is 0, and it falls on the edge at which `fv_floor` is sampled 0.
- R4: While `mod_on` is 1, each modulation period lasts PERIOD_TICKS ticks (default 32). `core_clk_en` is 1 during the first ON_TICKS ticks of the period (default 8, so 25%) and 0 during the rest. There is no input that changes this ratio.
- R5: The period phase moves forward only on a clock edge at which `tb_tick` is 1. Changing the number of core clocks between ticks never changes how many ticks the on and off phases last.
- R6: `tcc_on` falls on the tick edge that completes HYST_TICKS consecutive ticks (default 16) during which `over_tmax` was sampled 0 on every edge.
- R7: If `over_tmax` is sampled 1 while the hysteresis interval is still running, the tick count starts again from zero.
- R8: While `mod_on` is 0, `core_clk_en` is 1. After modulation stops, the next modulation begins at phase zero, with a full ON_TICKS on-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_tick | input | 1 | One-cycle strobe from the fixed 1 µs timebase |
| over_tmax | input | 1 | Die temperature is above its maximum |
| fv_floor | input | 1 | Frequency and voltage targets are at their minimum |
| core_clk_en | output | 1 | Enable for the gated core clock |
| tcc_on | output | 1 | Thermal control circuit is active |
| mod_on | output | 1 | Clock modulation is active |

## Verification
A phase counter that is off by one shows up directly on `core_clk_en`. The enable drops one tick early or late, or a period is the wrong length, and the first period after modulation starts already exposes this. A hysteresis counter that misses the restart rule, or expires early, makes `tcc_on` fall at the wrong tick on the first cool-down. A phase counter that is not cleared when modulation stops shows up as a short on-phase the next time modulation starts. The bench varies the spacing between ticks, so a counter that advanced on core clocks instead of ticks would fail within one period.

// File: rtl/thermal_clkmod.sv
module thermal_clkmod #(
  parameter int PERIOD_TICKS = 32,
  parameter int ON_TICKS     = 8,
  parameter int HYST_TICKS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_tick,
  input  logic over_tmax,
  input  logic fv_floor,
  output logic core_clk_en,
  output logic tcc_on,
  output logic mod_on
);
  localparam int PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int HW = (HYST_TICKS > 1) ? $clog2(HYST_TICKS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] PH_ON   = PW'(ON_TICKS);
  localparam logic [HW-1:0] HY_LAST = HW'(HYST_TICKS - 1);

  logic [PW-1:0] phase;
  logic [HW-1:0] hyst;
  logic          tcc_nxt, hyst_done;

  assign hyst_done = tcc_on && !over_tmax && tb_tick && (hyst == HY_LAST);
  assign tcc_nxt   = over_tmax || (tcc_on && !hyst_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcc_on <= 1'b0;
      hyst   <= '0;
    end else begin
      tcc_on <= tcc_nxt;
      if (over_tmax || !tcc_on || hyst_done) hyst <= '0;
      else if (tb_tick)                      hyst <= hyst + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_on <= 1'b0;
      phase  <= '0;
    end else begin
      mod_on <= tcc_nxt && fv_floor;
      if (!(tcc_nxt && fv_floor)) phase <= '0;
      else if (mod_on && tb_tick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  assign core_clk_en = !mod_on || (phase < PH_ON);

  assert_mod_needs_tcc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_on |-> tcc_on);
  assert_tcc_rise_hot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcc_on) |-> $past(over_tmax));
  assert_exit_on_cool_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tcc_on) |-> (!$past(over_tmax) && $past(tb_tick)));
  assert_en_high_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_on |-> core_clk_en);
  assert_start_on_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_on) |-> core_clk_en);
  assert_en_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && $past(mod_on) && !$past(tb_tick)) |-> $stable(core_clk_en));
endmodule

// File: tb/sim_thermal_clkmod.sv
module sim_thermal_clkmod;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 32, OT = 8, HT = 16;

  logic clk = 1'b0, rst_n = 1'b0, tb_tick = 1'b0, over_tmax = 1'b0, fv_floor = 1'b0;
  logic core_clk_en, tcc_on, mod_on;
  int vectors = 0, miscompares = 0;
  logic [2:0] expq[$];

  int m_ph = 0, m_hy = 0;
  logic m_tcc = 1'b0, m_mod = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_clkmod #(.PERIOD_TICKS(PT), .ON_TICKS(OT), .HYST_TICKS(HT)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .over_tmax(over_tmax),
    .fv_floor(fv_floor), .core_clk_en(core_clk_en), .tcc_on(tcc_on), .mod_on(mod_on));

  function automatic void cmp(string req, logic act, logic exp_v);
    vectors++;
    if (act !== exp_v) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp_v);
    end
  endfunction

  // Driver: one cycle of stimulus; the expected outputs after the next edge are
  // worked out from the requirements and queued.
  task automatic step(input logic hot, input logic fv, input logic tk);
    logic nt, nm;
    @(negedge clk);
    over_tmax = hot; fv_floor = fv; tb_tick = tk;
    // R2 set on hot, R6/R7 cool-tick counting with restart
    if (hot) begin nt = 1'b1; m_hy = 0; end
    else if (!m_tcc) begin nt = 1'b0; m_hy = 0; end
    else if (tk && m_hy == HT-1) begin nt = 1'b0; m_hy = 0; end
    else begin nt = 1'b1; if (tk) m_hy++; end
    // R3 entry/exit, R5 advance on ticks only, R8 restart at phase zero
    nm = nt && fv;
    if (!nm) m_ph = 0;
    else if (m_mod && tk) m_ph = (m_ph + 1) % PT;
    m_tcc = nt; m_mod = nm;
    expq.push_back({(!m_mod || m_ph < OT), m_tcc, m_mod});
  endtask

  task automatic run(input int n, input logic hot, input logic fv, input int every);
    for (int i = 0; i < n; i++) step(hot, fv, (i % every) == every - 1);
  endtask

  // Monitor: compares after each edge once the combinational output settles.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (expq.size() > 0) begin
        logic [2:0] e;
        e = expq.pop_front();
        cmp("R4 core_clk_en", core_clk_en, e[2]);
        cmp("R2/R6/R7 tcc_on", tcc_on, e[1]);
        cmp("R3 mod_on", mod_on, e[0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    cmp("R1 reset en", core_clk_en, 1'b1);
    cmp("R1 reset tcc", tcc_on, 1'b0);
    cmp("R1 reset mod", mod_on, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    run(10, 1'b0, 1'b0, 2);          // idle, R1
    run(20, 1'b1, 1'b0, 3);          // R2 hot without floor: no modulation
    run(PT*3*2, 1'b1, 1'b1, 3);      // R4 two periods, tick every 3 clocks
    run(PT*2, 1'b1, 1'b1, 1);        // R5 tick every clock
    run(PT*5, 1'b1, 1'b1, 5);        // R5 tick every 5 clocks
    run(10*2, 1'b0, 1'b1, 2);        // cooling, 10 ticks
    run(1, 1'b1, 1'b1, 1);           // R7 hot again restarts hysteresis
    run((HT-1)*2, 1'b0, 1'b1, 2);    // R7 one tick short: still active
    run(6, 1'b0, 1'b1, 2);           // R6 expiry, R8 enable returns high
    run(10, 1'b0, 1'b1, 1);
    run(PT*2, 1'b1, 1'b1, 2);        // R8 restart from phase zero
    run(12*2, 1'b1, 1'b1, 2);
    run(8, 1'b1, 1'b0, 2);           // R3 floor dropped stops modulation
    run(20, 1'b1, 1'b1, 2);          // R8 full on-phase again
    run(HT*2+4, 1'b0, 1'b0, 2);      // R6 exit without modulation
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule